// File: doc/BRIEF.md
# Bus Parity Error Monitor

This block sits beside a 32-bit PCI interface and checks even parity over the multiplexed address/data lines, the command/byte-enable lines and the parity line. The parity bit on the bus arrives one clock after the values it covers, so the monitor holds those values for a clock and checks them when parity arrives. It reports errors in two ways. An address-phase error produces a one-clock system-error pulse. A data-phase error produces a parity-error pulse one clock later than that. Both outputs are active-high enables for open-drain drivers that pull the pins low.

The surrounding interface gives the monitor its role for the current data phase (selected target, current master, write or read) and the two enable bits of the command register. The monitor keeps three sticky bits of the status register. Software clears them by writing ones. The status word is shown at its normal bit positions, and every other bit reads zero.

Top module: `pci_parity_monitor`

## Requirements
- R1: An error is flagged when the 37 bits made of the AD and C/BE# values sampled on one clock plus the parity line sampled on the next clock hold an odd number of ones.
- R2: The address phase is the first clock on which frame_n is sampled low. When its parity is wrong and serr_en is high on the parity clock, serr_oe is high for exactly the one clock after the parity clock. It stays low otherwise.
- R3: pci_status bit 14 sets together with every serr_oe pulse. It stays set until it is cleared or reset.
- R4: Data parity is checked only on clocks where irdy_n and trdy_n are both low. It is not checked when the command latched at the address phase is 4'b0001 (Special Cycle).
- R5: perr_oe is only asserted when perr_en is high and the block was either the target of a write (is_target and is_write) or the master of a read (is_master and not is_write) on the transfer clock.
- R6: perr_oe goes high in the second clock after the parity clock, i.e. one clock later than the matching serr_oe position. It lasts one clock for each error.
- R7: pci_status bit 15 sets on every checked data parity error, whatever the value of perr_en and whatever the role.
- R8: pci_status bit 8 sets on a checked data parity error only when is_master was high on the transfer clock and perr_en is high.
- R9: Writing with stat_wr clears each of bits 8, 14 and 15 whose stat_wdata bit is 1. A zero bit in stat_wdata has no effect. A set event on the same clock as a clear wins.
- R10: A synchronous low rst_n clears all status bits and pipeline state, and sets serr_oe and perr_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Address/data lines |
| cbe_n | input | 4 | Command/byte enables |
| par | input | 1 | Even parity, valid one clock after AD and C/BE# |
| is_target | input | 1 | Block is the selected target |
| is_master | input | 1 | Block is the current master |
| is_write | input | 1 | Current transaction is a write |
| serr_en | input | 1 | Command register system-error enable |
| perr_en | input | 1 | Command register parity-error response enable |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Status write data, ones clear |
| serr_oe | output | 1 | Pull system-error pin low |
| perr_oe | output | 1 | Pull parity-error pin low |
| pci_status | output | 16 | Status bits 15, 14, 8; rest zero |

## Verification
The assertions assume that the bus follows the protocol. This means frame_n is released for at least a clock between two address phases, so that two address phases never fall on neighbouring clocks, and the enables are ordinary levels. The stimulus runs each transaction as a full, legal sequence: an address clock, then a parity clock, then a single final data transfer with its parity clock, then idle clocks. It sweeps every mix of command type, role, address and data parity fault, both enables, and a status clear placed on the same clock as each set event.

// File: rtl/pci_parity_monitor.sv
module pci_parity_monitor #(
  parameter int ADW = 32,
  parameter int CBW = 4,
  parameter logic [3:0] SPECIAL_CMD = 4'b0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic [ADW-1:0]  ad,
  input  logic [CBW-1:0]  cbe_n,
  input  logic            par,
  input  logic            is_target,
  input  logic            is_master,
  input  logic            is_write,
  input  logic            serr_en,
  input  logic            perr_en,
  input  logic            stat_wr,
  input  logic [15:0]     stat_wdata,
  output logic            serr_oe,
  output logic            perr_oe,
  output logic [15:0]     pci_status
);
  localparam int B_RPT = 8;
  localparam int B_SYS = 14;
  localparam int B_DET = 15;

  logic           frame_prev, addr_pend, xfer_pend, drive_pend, mstr_pend;
  logic           special_q, perr_pend;
  logic           st_rpt, st_sys, st_det;
  logic [ADW-1:0] ad_q;
  logic [CBW-1:0] cbe_q;
  logic           addr_phase, xfer, odd, addr_err, data_err;
  logic           set_sys, set_det, set_rpt;

  assign addr_phase = ~frame_n & frame_prev;
  assign xfer       = ~irdy_n & ~trdy_n & ~special_q;
  assign odd        = ^{ad_q, cbe_q, par};
  assign addr_err   = addr_pend & odd;
  assign data_err   = xfer_pend & odd;
  assign set_sys    = addr_err & serr_en;
  assign set_det    = data_err;
  assign set_rpt    = data_err & mstr_pend & perr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_prev <= 1'b1;
      ad_q       <= '0;
      cbe_q      <= '0;
      addr_pend  <= 1'b0;
      xfer_pend  <= 1'b0;
      drive_pend <= 1'b0;
      mstr_pend  <= 1'b0;
      special_q  <= 1'b0;
      perr_pend  <= 1'b0;
      serr_oe    <= 1'b0;
      perr_oe    <= 1'b0;
      st_rpt     <= 1'b0;
      st_sys     <= 1'b0;
      st_det     <= 1'b0;
    end else begin
      frame_prev <= frame_n;
      ad_q       <= ad;
      cbe_q      <= cbe_n;
      addr_pend  <= addr_phase;
      if (addr_phase) special_q <= (cbe_n == SPECIAL_CMD);
      xfer_pend  <= xfer;
      drive_pend <= (is_target & is_write) | (is_master & ~is_write);
      mstr_pend  <= is_master;
      serr_oe    <= set_sys;
      perr_pend  <= data_err & drive_pend & perr_en;
      perr_oe    <= perr_pend;
      st_sys     <= set_sys | (st_sys & ~(stat_wr & stat_wdata[B_SYS]));
      st_det     <= set_det | (st_det & ~(stat_wr & stat_wdata[B_DET]));
      st_rpt     <= set_rpt | (st_rpt & ~(stat_wr & stat_wdata[B_RPT]));
    end
  end

  always_comb begin
    pci_status        = '0;
    pci_status[B_RPT] = st_rpt;
    pci_status[B_SYS] = st_sys;
    pci_status[B_DET] = st_det;
  end
endmodule

module pci_parity_monitor_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        serr_en,
  input logic        perr_en,
  input logic        serr_oe,
  input logic        perr_oe,
  input logic [15:0] pci_status
);
  assert_serr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |=> !serr_oe);
  assert_serr_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(serr_en));
  assert_serr_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> pci_status[14]);
  assert_sys_rise_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_status[14]) |-> $past(serr_en));
  assert_perr_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_oe |-> $past(perr_en, 2));
  assert_rpt_rise_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_status[8]) |-> $past(perr_en));
  assert_perr_flags_det_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_oe) |-> $past(pci_status[15]) || $past(perr_oe));
endmodule

bind pci_parity_monitor pci_parity_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .serr_en(serr_en), .perr_en(perr_en),
  .serr_oe(serr_oe), .perr_oe(perr_oe), .pci_status(pci_status));

// File: tb/pci_parity_monitor_test.sv
`timescale 1ns/1ps
module pci_parity_monitor_test;
  logic clk = 0, rst_n = 0;
  logic frame_n = 1, irdy_n = 1, trdy_n = 1, par = 0;
  logic [31:0] ad = 0;
  logic [3:0] cbe_n = 0;
  logic is_target = 0, is_master = 0, is_write = 0, serr_en = 0, perr_en = 0;
  logic stat_wr = 0;
  logic [15:0] stat_wdata = 0;
  logic serr_oe, perr_oe;
  logic [15:0] pci_status;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_parity_monitor uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt; @(negedge clk); endtask

  task automatic txn(input int idx, input logic [3:0] cmd, input bit abad, input bit dbad,
                     input bit se, input bit pe, input bit tgt, input bit race);
    logic [31:0] addr, data;
    logic [3:0] be;
    bit wr, qual, derr, drive, serr_x, perr_x;
    logic [15:0] st;
    addr = 32'h1000_0000 + idx * 32'h0103_0507;
    data = 32'hA5C3_0F11 ^ (idx * 32'h0011_2233);
    be = idx[3:0] ^ 4'h6;
    wr = (cmd != 4'b0110);
    qual = (cmd != 4'b0001);
    derr = dbad && qual;
    drive = (tgt && wr) || (!tgt && !wr);
    serr_x = abad && se;
    perr_x = derr && drive && pe;
    is_target = tgt; is_master = !tgt; is_write = wr; serr_en = se; perr_en = pe;
    // address clock
    frame_n = 0; ad = addr; cbe_n = cmd; par = idx[1];
    nxt;
    // parity clock for address (R1)
    par = (^{addr, cmd}) ^ abad; ad = ~addr; cbe_n = ~cmd;
    if (race) begin stat_wr = 1; stat_wdata = 16'hFFFF; end
    nxt;
    chk("R2 serr pulse", serr_oe, serr_x);
    chk("R3 sys status (R9 set wins)", pci_status[14], serr_x);
    stat_wr = 0;
    // data transfer clock
    frame_n = 1; irdy_n = 0; trdy_n = 0; ad = data; cbe_n = be; par = ~par;
    nxt;
    chk("R2 serr one clock", serr_oe, 0);
    irdy_n = 1; trdy_n = 1; ad = ~data;
    par = (^{data, be}) ^ dbad;
    if (race) begin stat_wr = 1; stat_wdata = 16'hFFFF; end
    nxt;
    st = 0;
    st[14] = serr_x && !race;
    st[15] = derr;
    st[8] = derr && !tgt && pe;
    chk("R6 perr not early", perr_oe, 0);
    chk("R4 R7 R8 status", pci_status, st);
    stat_wr = 0;
    nxt;
    chk("R5 R6 perr pulse", perr_oe, perr_x);
    nxt;
    chk("R6 perr one clock", perr_oe, 0);
    stat_wr = 1; stat_wdata = 16'h0000;
    nxt;
    chk("R9 zero write keeps", pci_status, st);
    stat_wdata = 16'hFFFF;
    nxt;
    chk("R9 clear", pci_status, 0);
    stat_wr = 0;
  endtask

  initial begin
    nxt; nxt;
    chk("R10 reset serr", serr_oe, 0);
    chk("R10 reset perr", perr_oe, 0);
    chk("R10 reset status", pci_status, 0);
    rst_n = 1;
    nxt;
    begin
      int idx = 0;
      for (int c = 0; c < 3; c++)
        for (int m = 0; m < 64; m++) begin
          logic [3:0] cmd;
          cmd = (c == 0) ? 4'b0001 : (c == 1) ? 4'b0111 : 4'b0110;
          txn(idx, cmd, m[0], m[1], m[2], m[3], m[4], m[5]);
          idx++;
        end
    end
    // reset with status set and a pulse pending
    txn(7, 4'b0110, 1, 1, 1, 1, 0, 0);
    is_target = 0; is_master = 1; is_write = 0; serr_en = 1; perr_en = 1;
    frame_n = 0; ad = 32'h1; cbe_n = 4'b0110; nxt;
    par = 1'b0; nxt;
    frame_n = 1; irdy_n = 0; trdy_n = 0; ad = 32'h3; cbe_n = 0; nxt;
    irdy_n = 1; trdy_n = 1; par = 1'b1; nxt;
    chk("R10 pre-reset status", pci_status, 16'hC100);
    rst_n = 0; nxt;
    chk("R10 reset clears perr", perr_oe, 0);
    chk("R10 reset clears status", pci_status, 0);
    rst_n = 1; nxt; nxt;
    chk("R10 no pulse after reset", perr_oe, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule